// File: doc/BRIEF.md
# DAC Code Gain and Offset Corrector

This block takes an ideal DAC code together with that channel's signed gain and offset trim coefficients, and returns the corrected code the converter should receive. The correction multiplies the code by one plus the gain trim over 2^18, then adds the offset trim over 4. The sum is rounded to the nearest integer, with halves rounded away from zero. Finally it is clamped to the legal code range, so an out-of-range result never wraps.

The datapath has three register stages and accepts a new sample on every clock. A valid strobe travels with each sample. A mode input selects how codes are read:
- Signed mode treats the input and output as two's-complement codes, clamped to -32768..32767.
- Unsigned mode treats them as straight binary, clamped to 0..65535.

The mode is sampled together with the data, so it may change from one sample to the next.

Top module: `dac_gain_offset_corr`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_valid` is 0 and `out_code` is 0.
- R2: A sample presented with `in_valid` high before clock edge N appears on `out_code`, with `out_valid` high, right after edge N+2. `out_valid` is low in every cycle that no sample produces.
- R3: The result is round(ideal*(1 + gain/262144) + offset/4). For example, ideal -8192 with gain -185 and offset -43 in signed mode gives -8197, which is 16'hDFFB.
- R4: With gain 0 and offset 0, the output equals the input code, in either mode, for any code.
- R5: Rounding goes to the nearest integer, with exact halves rounded away from zero. An offset of 2 gives +1, -2 gives -1, 1 gives 0, 3 gives +1 and -6 gives -2.
- R6: In signed mode (`code_mode` = 0), both the input and output are two's complement. Results above 32767 give 16'h7FFF, and results below -32768 give 16'h8000.
- R7: In unsigned mode (`code_mode` = 1), the input is read as 0..65535. Results below 0 give 16'h0000, and results above 65535 give 16'hFFFF.
- R8: Samples on consecutive clocks are each corrected with their own coefficients and mode, and leave in the order they entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code_mode | input | 1 | 0: signed codes, 1: unsigned codes; sampled with the data |
| in_valid | input | 1 | Sample strobe |
| in_ideal | input | 16 | Ideal code |
| in_gain | input | 16 | Signed gain trim, in units of 1/262144 |
| in_offset | input | 16 | Signed offset trim, in quarter codes |
| out_valid | output | 1 | Result strobe |
| out_code | output | 16 | Corrected, rounded and clamped code |

## Verification
The bench builds the block with its default parameters: 16-bit codes and coefficients, an 18-bit gain scale and a 16-bit offset pre-shift. With these values, the worked correction example, exact half-code offsets, and full-scale codes pushed past both ends of both ranges are all reachable with small directed stimulus. The extreme gain trims of plus and minus full scale exercise the widest product the accumulator must hold.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
  typedef enum logic {
    CODE_SIGNED   = 1'b0,
    CODE_UNSIGNED = 1'b1
  } code_mode_e;
endpackage

// File: rtl/dgc_mult_stage.sv
module dgc_mult_stage #(
  parameter int CODE_W     = 16,
  parameter int COEF_W     = 16,
  parameter int GAIN_SHIFT = 18,
  parameter int OFF_SHIFT  = 16,
  parameter int ACC_W      = 37,
  localparam int EXT_W     = CODE_W + 1,
  localparam int PROD_W    = EXT_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valid_i,
  input  dgc_pkg::code_mode_e      mode_i,
  input  logic [CODE_W-1:0]        ideal_i,
  input  logic signed [COEF_W-1:0] gain_i,
  input  logic signed [COEF_W-1:0] offset_i,
  output logic                     valid_o,
  output dgc_pkg::code_mode_e      mode_o,
  output logic signed [PROD_W-1:0] prod_o,
  output logic signed [ACC_W-1:0]  base_o
);
  // Widen the code to a signed value according to the mode.
  function automatic logic signed [EXT_W-1:0] widen(input logic [CODE_W-1:0] c,
                                                    input dgc_pkg::code_mode_e m);
    if (m == dgc_pkg::CODE_UNSIGNED) return {1'b0, c};
    return {c[CODE_W-1], c};
  endfunction

  logic signed [EXT_W-1:0] ext_code;
  logic signed [ACC_W-1:0] unity_term, off_term;

  always_comb begin
    ext_code   = widen(ideal_i, mode_i);
    unity_term = ACC_W'(ext_code) <<< GAIN_SHIFT;
    off_term   = ACC_W'(offset_i) <<< OFF_SHIFT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      mode_o  <= dgc_pkg::CODE_SIGNED;
      prod_o  <= '0;
      base_o  <= '0;
    end else begin
      valid_o <= valid_i;
      mode_o  <= mode_i;
      prod_o  <= PROD_W'(ext_code) * PROD_W'(gain_i);
      base_o  <= unity_term + off_term;
    end
  end
endmodule

// File: rtl/dgc_sum_stage.sv
module dgc_sum_stage #(
  parameter int PROD_W = 33,
  parameter int ACC_W  = 37
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valid_i,
  input  dgc_pkg::code_mode_e      mode_i,
  input  logic signed [PROD_W-1:0] prod_i,
  input  logic signed [ACC_W-1:0]  base_i,
  output logic                     valid_o,
  output dgc_pkg::code_mode_e      mode_o,
  output logic signed [ACC_W-1:0]  acc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      mode_o  <= dgc_pkg::CODE_SIGNED;
      acc_o   <= '0;
    end else begin
      valid_o <= valid_i;
      mode_o  <= mode_i;
      acc_o   <= base_i + ACC_W'(prod_i);
    end
  end
endmodule

// File: rtl/dgc_round_sat.sv
module dgc_round_sat #(
  parameter int CODE_W = 16,
  parameter int SHIFT  = 18,
  parameter int ACC_W  = 37
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    valid_i,
  input  dgc_pkg::code_mode_e     mode_i,
  input  logic signed [ACC_W-1:0] acc_i,
  output logic                    valid_o,
  output logic [CODE_W-1:0]       code_o
);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (SHIFT - 1));
  localparam logic signed [ACC_W-1:0] SMAX = ACC_W'((64'sd1 <<< (CODE_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] SMIN = ACC_W'(-(64'sd1 <<< (CODE_W - 1)));
  localparam logic signed [ACC_W-1:0] UMAX = ACC_W'((64'sd1 <<< CODE_W) - 64'sd1);
  localparam logic [CODE_W-1:0] CODE_SMAX = {1'b0, {(CODE_W-1){1'b1}}};
  localparam logic [CODE_W-1:0] CODE_SMIN = {1'b1, {(CODE_W-1){1'b0}}};

  // Nearest integer of acc / 2^SHIFT, halves away from zero.
  function automatic logic signed [ACC_W-1:0] round_away(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] b;
    b = a + HALF - ACC_W'(a[ACC_W-1]);
    return b >>> SHIFT;
  endfunction

  logic signed [ACC_W-1:0] rnd, hi_lim, lo_lim, round_err;
  logic                    sat_hi, sat_lo;
  logic [CODE_W-1:0]       code_next;

  always_comb begin
    rnd       = round_away(acc_i);
    hi_lim    = (mode_i == dgc_pkg::CODE_UNSIGNED) ? UMAX : SMAX;
    lo_lim    = (mode_i == dgc_pkg::CODE_UNSIGNED) ? '0 : SMIN;
    sat_hi    = rnd > hi_lim;
    sat_lo    = rnd < lo_lim;
    round_err = acc_i - (rnd <<< SHIFT);
    if (sat_hi)      code_next = hi_lim[CODE_W-1:0];
    else if (sat_lo) code_next = lo_lim[CODE_W-1:0];
    else             code_next = rnd[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else begin
      valid_o <= valid_i;
      code_o  <= code_next;
    end
  end

  // R5: an unclamped result is within half a code of the exact value
  a_r5_round_nearest: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !sat_hi && !sat_lo) |-> (round_err <= HALF && round_err >= -HALF));
  // R6: signed overflow lands on the top signed code
  a_r6_signed_clamp: assert property (@(posedge clk) disable iff (rst)
    (valid_i && sat_hi && mode_i == dgc_pkg::CODE_SIGNED) |=> (code_o == CODE_SMAX));
  // R6: signed underflow lands on the bottom signed code
  a_r6_signed_floor: assert property (@(posedge clk) disable iff (rst)
    (valid_i && sat_lo && mode_i == dgc_pkg::CODE_SIGNED) |=> (code_o == CODE_SMIN));
  // R7: unsigned underflow lands on zero
  a_r7_unsigned_floor: assert property (@(posedge clk) disable iff (rst)
    (valid_i && sat_lo && mode_i == dgc_pkg::CODE_UNSIGNED) |=> (code_o == '0));
endmodule

// File: rtl/dac_gain_offset_corr.sv
module dac_gain_offset_corr #(
  parameter int CODE_W     = 16,
  parameter int COEF_W     = 16,
  parameter int GAIN_SHIFT = 18,
  parameter int OFF_SHIFT  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              code_mode,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_ideal,
  input  logic [COEF_W-1:0] in_gain,
  input  logic [COEF_W-1:0] in_offset,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code
);
  localparam int EXT_W  = CODE_W + 1;
  localparam int PROD_W = EXT_W + COEF_W;
  localparam int UNI_W  = EXT_W + GAIN_SHIFT;
  localparam int OFS_W  = COEF_W + OFF_SHIFT;
  localparam int WIDE_W = (UNI_W > PROD_W) ? UNI_W : PROD_W;
  localparam int ACC_W  = ((WIDE_W > OFS_W) ? WIDE_W : OFS_W) + 2;

  dgc_pkg::code_mode_e     mode_in, mode_s1, mode_s2;
  logic                    valid_s1, valid_s2;
  logic signed [PROD_W-1:0] prod_s1;
  logic signed [ACC_W-1:0]  base_s1, acc_s2;

  assign mode_in = code_mode ? dgc_pkg::CODE_UNSIGNED : dgc_pkg::CODE_SIGNED;

  dgc_mult_stage #(
    .CODE_W(CODE_W), .COEF_W(COEF_W), .GAIN_SHIFT(GAIN_SHIFT),
    .OFF_SHIFT(OFF_SHIFT), .ACC_W(ACC_W)
  ) u_mult (
    .clk(clk), .rst(rst), .valid_i(in_valid), .mode_i(mode_in),
    .ideal_i(in_ideal), .gain_i($signed(in_gain)), .offset_i($signed(in_offset)),
    .valid_o(valid_s1), .mode_o(mode_s1), .prod_o(prod_s1), .base_o(base_s1)
  );

  dgc_sum_stage #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_sum (
    .clk(clk), .rst(rst), .valid_i(valid_s1), .mode_i(mode_s1),
    .prod_i(prod_s1), .base_i(base_s1),
    .valid_o(valid_s2), .mode_o(mode_s2), .acc_o(acc_s2)
  );

  dgc_round_sat #(.CODE_W(CODE_W), .SHIFT(GAIN_SHIFT), .ACC_W(ACC_W)) u_rsat (
    .clk(clk), .rst(rst), .valid_i(valid_s2), .mode_i(mode_s2), .acc_i(acc_s2),
    .valid_o(out_valid), .code_o(out_code)
  );

  // Cycles since reset, so the latency check never reaches before reset.
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R1: reset clears the output strobe
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!out_valid && out_code == '0));
  // R2: output strobe is the input strobe three clocks later
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));
endmodule

// File: tb/sim_dac_gain_offset_corr.sv
module sim_dac_gain_offset_corr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        code_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_ideal = '0, in_gain = '0, in_offset = '0;
  logic        out_valid;
  logic [15:0] out_code;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  dac_gain_offset_corr u0 (
    .clk(clk), .rst(rst), .code_mode(code_mode), .in_valid(in_valid),
    .in_ideal(in_ideal), .in_gain(in_gain), .in_offset(in_offset),
    .out_valid(out_valid), .out_code(out_code)
  );

  // Reference: exact value times 4*65536, rounded by magnitude, then clamped.
  function automatic int model(input int ideal, input int gain, input int off, input bit uns);
    longint num, mag, r;
    num = longint'(ideal) * (longint'(262144) + gain) + longint'(off) * 65536;
    mag = (num < 0) ? -num : num;
    r = (mag + 131072) / 262144;
    if (num < 0) r = -r;
    if (uns) begin
      if (r < 0) r = 0;
      if (r > 65535) r = 65535;
    end else begin
      if (r < -32768) r = -32768;
      if (r > 32767) r = 32767;
    end
    return int'(r);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One sample through the pipe; ideal given as integer in the mode's range.
  task automatic one(input string req, input int ideal, input int gain, input int off, input bit uns);
    @(negedge clk);
    code_mode = uns; in_valid = 1'b1;
    in_ideal = 16'(ideal); in_gain = 16'(gain); in_offset = 16'(off);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    check({req, " strobe low early"}, {15'd0, out_valid}, 16'd0);
    @(negedge clk);
    check({req, " strobe"}, {15'd0, out_valid}, 16'd1);
    check(req, out_code, 16'(model(ideal, gain, off, uns)));
    @(negedge clk);
    check({req, " strobe drops"}, {15'd0, out_valid}, 16'd0);
  endtask

  task automatic t_reset;
    check("R1 valid", {15'd0, out_valid}, 16'd0);
    check("R1 code", out_code, 16'd0);
  endtask

  task automatic t_example;
    one("R3 worked example", -8192, -185, -43, 1'b0);
    check("R3 code DFFB", out_code, 16'hDFFB);
    one("R3 max gain", 16384, 32767, 0, 1'b0);
    one("R3 min gain", -16384, -32768, 0, 1'b0);
    one("R2 latency", 1000, 500, 7, 1'b0);
  endtask

  task automatic t_identity;
    one("R4 signed neg", -12345, 0, 0, 1'b0);
    one("R4 signed pos", 32767, 0, 0, 1'b0);
    one("R4 unsigned", 40000, 0, 0, 1'b1);
  endtask

  task automatic t_round;
    one("R5 +half", 0, 0, 2, 1'b0);
    one("R5 -half", 0, 0, -2, 1'b0);
    one("R5 quarter", 0, 0, 1, 1'b0);
    one("R5 three quarters", 0, 0, 3, 1'b0);
    one("R5 -1.5", 0, 0, -6, 1'b0);
  endtask

  task automatic t_signed_sat;
    one("R6 high", 32767, 0, 32767, 1'b0);
    one("R6 low", -32768, 0, -32768, 1'b0);
    one("R6 high gain", 32000, 32767, 0, 1'b0);
  endtask

  task automatic t_unsigned_sat;
    one("R7 low", 0, 0, -8, 1'b1);
    one("R7 high", 65535, 0, 100, 1'b1);
    one("R7 mid", 50000, -1000, 40, 1'b1);
  endtask

  task automatic t_stream;
    int idl[4] = '{-8192, 60000, 5, 32767};
    int gn[4]  = '{-185, 0, 0, 32767};
    int of[4]  = '{-43, 12, -6, 0};
    bit um[4]  = '{1'b0, 1'b1, 1'b0, 1'b0};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i >= 3 && i < 7) begin
        check("R8 stream strobe", {15'd0, out_valid}, 16'd1);
        check("R8 stream data", out_code, 16'(model(idl[i-3], gn[i-3], of[i-3], um[i-3])));
      end
      if (i == 7) check("R2 stream end", {15'd0, out_valid}, 16'd0);
      if (i < 4) begin
        in_valid = 1'b1; code_mode = um[i];
        in_ideal = 16'(idl[i]); in_gain = 16'(gn[i]); in_offset = 16'(of[i]);
      end else in_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {15'd0, out_valid}, 16'd0);
    t_example();
    t_identity();
    t_round();
    t_signed_sat();
    t_unsigned_sat();
    t_stream();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule